// File: doc/BRIEF.md
# Flagged Hit Concentrator

The block gathers trigger hits from 32 serial front-end lines. The block divides time into bunch crossings of eight sample clocks. In each crossing, any line can announce a hit with a flag bit, followed by a 6-bit strip address. A programmable delay on each line lines up the flag with the crossing boundary. The block then picks up to eight flagged lines, giving priority to the lowest line index. It shifts in the addresses of the selected lines only, and it counts the hits that did not fit.

For each crossing the block builds one 112-bit frame. The frame carries a fixed header, the crossing number, a hit count and eight hit slots of {line ID, address}. The frame leaves the block on 14 lanes, eight bits per lane per crossing, while the next crossing is being collected. A sync strobe marks the first bit of each frame.

Top module: `hit_concentrator`

## Requirements
- R1: While `rst` is high, `lane_o`, `lane_sync_o` and `drop_cnt_o` are all zero. The first rising edge with `rst` low is slot 0 of crossing 0. A crossing lasts eight clock edges (slots 0 to 7).
- R2: A write with `cfg_we_i` high sets the delay of line `cfg_idx_i` to `cfg_dly_i`, a value from 0 to 7. Reset clears every delay to 0. With delay d, each slot's bit of a line is taken from the value that the line carried d edges earlier.
- R3: Among the lines flagged in a crossing, the lowest-indexed ones are chosen, at most eight. Frame slot 0 holds the lowest chosen index, and the slots continue in ascending index order.
- R4: On each line, slot 0 carries the flag (1 = hit). Slots 1 to 6 carry the address, MSB first, and slot 7 is ignored. Address bits on lines that are not flagged, or not chosen, have no effect on the frame.
- R5: Frame layout, from bit 111 down to bit 0: header 8'hA5 [111:104], crossing number [103:92], hit count [91:88], then slot k at [11k+10 : 11k] holding {5-bit line ID, 6-bit address}.
- R6: `drop_cnt_o` increases by the number of flags beyond eight in each crossing. It saturates at 255.
- R7: Lane j carries frame bits [8j+7 : 8j], MSB first, over eight consecutive cycles. `lane_sync_o` is high for exactly one cycle, the cycle that carries the first bit. The frame of crossing n starts in the cycle after edge 8n+7.
- R8: The crossing number in the frame counts crossings since reset, starting at 0. It wraps at 12 bits.
- R9: The hit count equals the number of chosen hits. Slots beyond the count are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, eight cycles per crossing |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | 32 | One serial trigger line per front-end input |
| cfg_we_i | input | 1 | Delay write strobe |
| cfg_idx_i | input | 5 | Line whose delay is written |
| cfg_dly_i | input | 3 | Delay value in sample clocks |
| lane_o | output | 14 | Output lanes, one frame bit each per cycle |
| lane_sync_o | output | 1 | High with the first bit of each frame |
| drop_cnt_o | output | 8 | Saturating count of hits that did not fit |

## Verification
The assertions check invariants on every cycle:
- The chosen set stays contiguous from slot 0, with IDs strictly ascending.
- The hit count matches the number of valid slots.
- The drop counter never decreases and stays at its ceiling once it reaches it.
- The sync strobe lasts a single cycle, always at a crossing boundary.

Only the scenarios can show the rest: that per-line delays align flags and addresses correctly, that address bits on unflagged lines are ignored, that the frame fields land in the right lane bits, and that the drop count reaches exact values before it saturates.

// File: rtl/hitc_pkg.sv
package hitc_pkg;
    localparam int NUM_IN    = 32;
    localparam int SEL       = 8;
    localparam int ADDR_W    = 6;
    localparam int ID_W      = $clog2(NUM_IN);
    localparam int BCID_W    = 12;
    localparam int CNT_W     = $clog2(SEL + 1);
    localparam int HDR_W     = 8;
    localparam int SLOTS     = 8;
    localparam int SLOT_W    = $clog2(SLOTS);
    localparam int HIT_W     = ID_W + ADDR_W;
    localparam int HITS_BITS = SEL * HIT_W;
    localparam int FRAME_W   = HDR_W + BCID_W + CNT_W + HITS_BITS;
    localparam int LANE_W    = SLOTS;
    localparam int LANES     = FRAME_W / LANE_W;
    localparam int POP_W     = $clog2(NUM_IN + 1);

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [ADDR_W-1:0] addr;
    } hit_t;

    function automatic logic [ID_W-1:0] first_set(input logic [NUM_IN-1:0] v);
        logic [ID_W-1:0] r;
        r = '0;
        for (int i = NUM_IN - 1; i >= 0; i--)
            if (v[i]) r = ID_W'(i);
        return r;
    endfunction

    function automatic logic [POP_W-1:0] ones(input logic [NUM_IN-1:0] v);
        logic [POP_W-1:0] c;
        c = '0;
        for (int i = 0; i < NUM_IN; i++)
            c = c + POP_W'(v[i]);
        return c;
    endfunction
endpackage

// File: rtl/hitc_delay_line.sv
module hitc_delay_line #(
    parameter int DEPTH = 8,
    localparam int DW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          din_i,
    input  logic          cfg_we_i,
    input  logic [DW-1:0] cfg_dly_i,
    output logic          dout_o
);
    logic [DEPTH-2:0] hist_q;
    logic [DW-1:0]    dly_q;
    logic [DEPTH-1:0] taps;

    assign taps   = {hist_q, din_i};
    assign dout_o = taps[dly_q];

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
            dly_q  <= '0;
        end else begin
            hist_q <= {hist_q[DEPTH-3:0], din_i};
            if (cfg_we_i) dly_q <= cfg_dly_i;
        end
    end
endmodule

// File: rtl/hitc_prio_select.sv
module hitc_prio_select
    import hitc_pkg::*;
#(
    parameter int K = SEL
) (
    input  logic [NUM_IN-1:0]         flags_i,
    output logic [K-1:0][ID_W-1:0]    id_o,
    output logic [K-1:0]              vld_o
);
    logic [NUM_IN-1:0] rem [K+1];
    logic [ID_W-1:0]   id_c [K];

    assign rem[0] = flags_i;

    for (genvar k = 0; k < K; k++) begin : g_stage
        assign id_c[k]    = first_set(rem[k]);
        assign vld_o[k]   = |rem[k];
        assign id_o[k]    = id_c[k];
        assign rem[k+1]   = rem[k] & ~(NUM_IN'(1) << id_c[k]);
    end
endmodule

// File: rtl/hitc_lane_serializer.sv
module hitc_lane_serializer #(
    parameter int NL = 14,
    parameter int LW = 8,
    localparam int FW = NL * LW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic [FW-1:0] frame_i,
    output logic [NL-1:0] lane_o,
    output logic          sync_o
);
    logic [FW-1:0] sh_q;
    logic          sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            sync_q <= 1'b0;
        end else begin
            sync_q <= load_i;
            if (load_i) sh_q <= frame_i;
            else
                for (int j = 0; j < NL; j++)
                    sh_q[j*LW +: LW] <= {sh_q[j*LW +: LW-1], 1'b0};
        end
    end

    for (genvar j = 0; j < NL; j++) begin : g_lane
        assign lane_o[j] = sh_q[j*LW + LW - 1];
    end
    assign sync_o = sync_q;

    assert_sync_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        sync_q |=> !sync_q);
endmodule

// File: rtl/hit_concentrator.sv
module hit_concentrator
    import hitc_pkg::*;
#(
    parameter int          DROP_W = 8,
    parameter logic [7:0]  HEADER = 8'hA5
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_IN-1:0]     line_i,
    input  logic                  cfg_we_i,
    input  logic [ID_W-1:0]       cfg_idx_i,
    input  logic [SLOT_W-1:0]     cfg_dly_i,
    output logic [LANES-1:0]      lane_o,
    output logic                  lane_sync_o,
    output logic [DROP_W-1:0]     drop_cnt_o
);
    logic [NUM_IN-1:0]            aligned;
    logic [SEL-1:0][ID_W-1:0]     sel_id_c, sel_id_q;
    logic [SEL-1:0]               sel_vld_c, sel_vld_q;
    logic [SEL-1:0][ADDR_W-1:0]   addr_q;
    logic [SLOT_W-1:0]            slot_q;
    logic [BCID_W-1:0]            bcid_q, bcid_cap_q;
    logic [CNT_W-1:0]             cnt_q;
    logic [DROP_W-1:0]            drop_q;
    logic [POP_W-1:0]             pop;
    logic [POP_W-1:0]             excess;
    logic [DROP_W:0]              drop_sum;
    logic [FRAME_W-1:0]           frame;
    logic                         load;

    for (genvar i = 0; i < NUM_IN; i++) begin : g_dly
        hitc_delay_line #(.DEPTH(SLOTS)) u_dl (
            .clk      (clk),
            .rst      (rst),
            .din_i    (line_i[i]),
            .cfg_we_i (cfg_we_i && (cfg_idx_i == ID_W'(i))),
            .cfg_dly_i(cfg_dly_i),
            .dout_o   (aligned[i])
        );
    end

    hitc_prio_select #(.K(SEL)) u_sel (
        .flags_i(aligned),
        .id_o   (sel_id_c),
        .vld_o  (sel_vld_c)
    );

    assign pop      = ones(aligned);
    assign excess   = (pop > POP_W'(SEL)) ? pop - POP_W'(SEL) : '0;
    assign drop_sum = {1'b0, drop_q} + (DROP_W+1)'(excess);

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q     <= '0;
            bcid_q     <= '0;
            bcid_cap_q <= '0;
            sel_id_q   <= '0;
            sel_vld_q  <= '0;
            addr_q     <= '0;
            cnt_q      <= '0;
            drop_q     <= '0;
        end else begin
            slot_q <= slot_q + 1'b1;
            if (slot_q == SLOT_W'(SLOTS - 1)) bcid_q <= bcid_q + 1'b1;
            if (slot_q == '0) begin
                sel_id_q   <= sel_id_c;
                sel_vld_q  <= sel_vld_c;
                bcid_cap_q <= bcid_q;
                addr_q     <= '0;
                cnt_q      <= (pop > POP_W'(SEL)) ? CNT_W'(SEL) : CNT_W'(pop);
                drop_q     <= drop_sum[DROP_W] ? '1 : drop_sum[DROP_W-1:0];
            end else if (slot_q <= SLOT_W'(ADDR_W)) begin
                for (int k = 0; k < SEL; k++)
                    addr_q[k] <= {addr_q[k][ADDR_W-2:0], aligned[sel_id_q[k]]};
            end
        end
    end

    always_comb begin
        hit_t h;
        frame = '0;
        frame[FRAME_W-1 -: HDR_W]           = HEADER;
        frame[HITS_BITS+CNT_W +: BCID_W]    = bcid_cap_q;
        frame[HITS_BITS +: CNT_W]           = cnt_q;
        for (int k = 0; k < SEL; k++) begin
            h.id   = sel_id_q[k];
            h.addr = addr_q[k];
            if (sel_vld_q[k]) frame[k*HIT_W +: HIT_W] = h;
        end
    end

    assign load = (slot_q == SLOT_W'(SLOTS - 1));

    hitc_lane_serializer #(.NL(LANES), .LW(LANE_W)) u_ser (
        .clk    (clk),
        .rst    (rst),
        .load_i (load),
        .frame_i(frame),
        .lane_o (lane_o),
        .sync_o (lane_sync_o)
    );

    assign drop_cnt_o = drop_q;

    for (genvar k = 0; k < SEL - 1; k++) begin : g_chk
        assert_vld_prefix_R3: assert property (@(posedge clk) disable iff (rst)
            sel_vld_q[k+1] |-> sel_vld_q[k]);
        assert_id_order_R3: assert property (@(posedge clk) disable iff (rst)
            sel_vld_q[k+1] |-> (sel_id_q[k+1] > sel_id_q[k]));
    end

    assert_cnt_match_R9: assert property (@(posedge clk) disable iff (rst)
        cnt_q == CNT_W'($countones(sel_vld_q)));

    assert_drop_mono_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> drop_q >= $past(drop_q));

    assert_drop_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (drop_q == '1) |=> (drop_q == '1));

    assert_sync_slot_R7: assert property (@(posedge clk) disable iff (rst)
        lane_sync_o |-> (slot_q == '0));
endmodule

// File: tb/hit_concentrator_tb.sv
module hit_concentrator_tb;
    localparam int NX    = 32;
    localparam int TOTAL = NX * 8 + 24;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] line_i = '0;
    logic        cfg_we_i = 1'b0;
    logic [4:0]  cfg_idx_i = '0;
    logic [2:0]  cfg_dly_i = '0;
    logic [13:0] lane_o;
    logic        lane_sync_o;
    logic [7:0]  drop_cnt_o;

    always #2.5 clk = ~clk;

    hit_concentrator u_dut (
        .clk(clk), .rst(rst), .line_i(line_i),
        .cfg_we_i(cfg_we_i), .cfg_idx_i(cfg_idx_i), .cfg_dly_i(cfg_dly_i),
        .lane_o(lane_o), .lane_sync_o(lane_sync_o), .drop_cnt_o(drop_cnt_o)
    );

    logic [31:0]  stim [TOTAL];
    logic [31:0]  flg [NX];
    logic [5:0]   addr_of [NX][32];
    logic [2:0]   dtab [32];
    logic [111:0] exp_q [$];
    int checks = 0, fails = 0, nfr = 0, edge_no = 0;
    bit done = 0;

    always @(posedge clk) edge_no <= rst ? 0 : edge_no + 1;

    task automatic chk(input bit ok, input string req, input logic [111:0] act, input logic [111:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [111:0] exp_frame(input int n);
        logic [111:0] f;
        int k;
        f = '0;
        k = 0;
        f[111:104] = 8'hA5;
        f[103:92]  = 12'(n);
        for (int i = 0; i < 32; i++)
            if (flg[n][i] && k < 8) begin
                f[k*11 +: 11] = {5'(i), addr_of[n][i]};
                k++;
            end
        f[91:88] = 4'(k);
        return f;
    endfunction

    task automatic hit(input int n, input int i, input logic [5:0] a);
        flg[n][i] = 1'b1;
        addr_of[n][i] = a;
    endtask

    // monitor: collects one frame per sync and compares with scoreboard
    initial begin
        logic [111:0] fr, e;
        forever begin
            @(negedge clk);
            if (!rst && lane_sync_o) begin
                chk(edge_no % 8 == 0, "R7 sync timing", 112'(edge_no), 112'(0));
                for (int s = 0; s < 8; s++) begin
                    if (s > 0) @(negedge clk);
                    for (int j = 0; j < 14; j++) fr[j*8 + 7 - s] = lane_o[j];
                end
                if (exp_q.size() > 0) begin
                    e = exp_q.pop_front();
                    nfr++;
                    chk(fr == e, "R2 R3 R4 R5 R8 R9 frame", fr, e);
                end
            end
        end
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        for (int c = 0; c < TOTAL; c++) stim[c] = '0;
        for (int n = 0; n < NX; n++) begin
            flg[n] = '0;
            for (int i = 0; i < 32; i++) addr_of[n][i] = '0;
        end
        for (int i = 0; i < 32; i++) dtab[i] = 3'((i * 5 + 3) % 8);

        // scenarios (crossings 0..4 idle while delays are written)
        hit(5, 3, 6'h2A);
        hit(6, 0, 6'h3F); hit(6, 31, 6'h00);
        for (int i = 4; i < 12; i++) hit(7, i, 6'(i * 7));
        hit(8, 1, 6'h01); hit(8, 5, 6'h15); hit(8, 7, 6'h27); hit(8, 9, 6'h09);
        hit(8, 12, 6'h30); hit(8, 15, 6'h0F); hit(8, 20, 6'h14); hit(8, 25, 6'h19);
        hit(8, 28, 6'h1C); hit(8, 30, 6'h1E);
        for (int i = 0; i < 32; i++) hit(9, i, 6'(i));
        for (int n = 11; n < 23; n++)
            for (int i = 0; i < 32; i++) hit(n, i, 6'(63 - i));
        seed = 32'h1234_5678;
        for (int n = 23; n < 31; n++) begin
            logic [31:0] r1;
            seed = seed * 1664525 + 1013904223; r1 = seed;
            seed = seed * 1664525 + 1013904223;
            for (int i = 0; i < 32; i++)
                if (r1[i] & seed[i]) hit(n, i, 6'(seed[i+:6] ^ 6'(i)));
        end

        for (int n = 0; n < NX; n++)
            for (int i = 0; i < 32; i++)
                if (flg[n][i])
                    for (int s = 0; s < 7; s++)
                        if (s == 0 || addr_of[n][i][6 - s])
                            stim[8*n + s - int'(dtab[i])][i] = 1'b1;
        // R4: address bits on unflagged line 10 and slot-7 noise on line 3
        for (int s = 1; s < 7; s++) stim[48 + s - int'(dtab[10])][10] = 1'b1;
        stim[47 - int'(dtab[3])][3] = 1'b1;

        for (int n = 0; n < NX; n++) exp_q.push_back(exp_frame(n));

        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(lane_o == '0 && !lane_sync_o && drop_cnt_o == '0, "R1 reset outputs",
            112'({lane_o, lane_sync_o, drop_cnt_o}), 112'(0));
        rst = 1'b0;
        for (int c = 0; c < TOTAL; c++) begin
            line_i    = stim[c];
            cfg_we_i  = (c < 32);
            cfg_idx_i = 5'(c);
            cfg_dly_i = dtab[c % 32];
            @(posedge clk);
            @(negedge clk);
            if (c == 63) chk(drop_cnt_o == 8'd0, "R6 no drop at exactly eight", 112'(drop_cnt_o), 112'(0));
            if (c == 64) chk(drop_cnt_o == 8'd2, "R6 two dropped", 112'(drop_cnt_o), 112'(2));
            if (c == 72) chk(drop_cnt_o == 8'd26, "R6 all flagged", 112'(drop_cnt_o), 112'(26));
        end
        cfg_we_i = 1'b0;
        line_i = '0;
        repeat (16) @(negedge clk);
        chk(nfr == NX, "R7 frame count", 112'(nfr), 112'(NX));
        chk(drop_cnt_o == 8'hFF, "R6 saturation", 112'(drop_cnt_o), 112'(255));
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule